// File: doc/BRIEF.md
# Reset Output and PLL Start-up Sequencer

This block drives the chip-wide reset output and the enable that lets the PLL clocks reach the core. It takes two reset requests: a primary reset and a secondary reset that is used for I/O resets and for entry to the power-off state. Either one forces the reset output high in the same cycle. After both have dropped, the output stays high for a programmable settling time. That time is counted on a slow reference tick. Only when it has run out are the clocks let through to the core.

The settling time comes from a small encoded field. A code `c` selects a duration of `BASE_TICKS << c` ticks. With a 1 ms tick and the default settings, the reset code gives 4 ms. The primary reset puts the field back to its reset code. The secondary reset leaves it as programmed. Through this difference alone, the block behaves differently for three cases:
- a cold boot or warm reset, which uses the default time;
- an I/O reset, which uses the programmed time;
- a wake-up from the power-off state, which also uses the programmed time.

Software can write the field only while the core is running, and it can always read the field back. The reset inputs and the write port are taken to be synchronous to `clk`. `por_n` is the block's own power-on reset. It is asserted asynchronously and released through a two-flop synchronizer.

Top module: `rst_seq_top`

## Requirements
- R1: While `pri_rst` or `sec_rst` is 1, `rst_drv` is 1 in that same cycle, with no register delay.
- R2: The first clock edge at which both reset inputs are 0 loads the start-up count D = `BASE_TICKS << code`; no tick is counted at that edge. `rst_drv` then stays 1 until D clock edges with `tick`=1 have followed, and falls right after the D-th.
- R3: `clk_gate_en` is always the inverse of `rst_drv`; the core clocks run only while the reset output is 0.
- R4: A clock edge with `pri_rst`=1 sets the start-up code to `DEFAULT_CODE`. `cfg_rd_code` shows the code at all times.
- R5: The secondary reset leaves the start-up code unchanged. After a secondary reset and its release, the count uses the code that was programmed before.
- R6: If either reset input goes to 1 while the count is running, the count is cancelled. A later release starts a full new count of D ticks.
- R7: A write (`cfg_wr_en`=1) updates the code at the next edge only when `rst_drv` is 0. A write made while `rst_drv` is 1 is ignored.
- R8: Ticks that arrive while a reset input is 1 are not counted. Edges without a tick do not advance the count.
- R9: While `por_n` is low, and after it is released, `rst_drv` is 1 and the code equals `DEFAULT_CODE`. A full count is needed before `rst_drv` first falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Block power-on reset, active low, asynchronous assert |
| pri_rst | input | 1 | Primary reset request, active high |
| sec_rst | input | 1 | Secondary (I/O / power-off) reset request, active high |
| tick | input | 1 | Slow reference tick, one-cycle pulse |
| cfg_wr_en | input | 1 | Start-up code write strobe |
| cfg_wr_code | input | CODE_W | Start-up code to write |
| cfg_rd_code | output | CODE_W | Current start-up code |
| rst_drv | output | 1 | Reset output, active high |
| clk_gate_en | output | 1 | Core clock enable, high when the core may run |

## Verification
A wrong timer state shows up at `rst_drv` within one tick of the point where the release should occur. An off-by-one load or a counted idle edge moves the falling edge by exactly one tick. A missed cancel shows up as the output falling too early after a re-release. A wrong start-up code is visible at once on `cfg_rd_code`. A secondary reset that wrongly touches the code shows up as a count length that does not match the programmed code. The bench steps ticks one at a time and checks the output before and after each one, so every such error is caught at the exact tick where it takes effect.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } rsq_state_e;
endpackage

// File: rtl/rsq_rst_sync.sv
module rsq_rst_sync (
  input  logic clk,
  input  logic por_n,
  output logic rst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n = sync_q;
endmodule

// File: rtl/rsq_cfg_reg.sv
module rsq_cfg_reg #(
  parameter int CODE_W       = 2,
  parameter int DEFAULT_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_rst,
  input  logic              core_run,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] DEF_C = CODE_W'(DEFAULT_CODE);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic              code_en;

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    if (pri_rst) begin
      code_en = 1'b1;
      code_d  = DEF_C;
    end else if (wr_en && core_run) begin
      code_en = 1'b1;
      code_d  = wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= DEF_C;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;

  AST_PRI_LOADS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    pri_rst |=> (code_q == DEF_C)); // R4
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_run && !pri_rst) |=> $stable(code_q)); // R7
endmodule

// File: rtl/rsq_dur_decode.sv
module rsq_dur_decode #(
  parameter int CODE_W     = 2,
  parameter int BASE_TICKS = 4,
  parameter int CNT_W      = 5
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  ticks
);
  localparam int NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] tbl [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_tbl
    assign tbl[g] = CNT_W'(BASE_TICKS << g);
  end

  assign ticks = tbl[code];
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer
  import rsq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_req,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  rsq_state_e       state_q;
  rsq_state_e       state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_HOLD: begin
        if (!hold_req) begin
          state_d = ST_COUNT;
          cnt_d   = load_val;
          cnt_en  = 1'b1;
        end
      end
      ST_COUNT: begin
        if (hold_req) begin
          state_d = ST_HOLD;
        end else if (tick) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
          if (cnt_q <= CNT_W'(1)) state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (hold_req) state_d = ST_HOLD;
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (state_q != ST_RUN);

  AST_RUN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick)); // R2
  AST_CANCEL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |=> (state_q == ST_HOLD)); // R6
  AST_IDLE_EDGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && !tick && !hold_req) |=> ($stable(cnt_q) && state_q == ST_COUNT)); // R8
  AST_NO_COUNT_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT) |-> (cnt_q != '0)); // R2
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int CODE_W       = 2,
  parameter int BASE_TICKS   = 4,
  parameter int DEFAULT_CODE = 0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pri_rst,
  input  logic              sec_rst,
  input  logic              tick,
  input  logic              cfg_wr_en,
  input  logic [CODE_W-1:0] cfg_wr_code,
  output logic [CODE_W-1:0] cfg_rd_code,
  output logic              rst_drv,
  output logic              clk_gate_en
);
  localparam int NCODES = 1 << CODE_W;
  localparam int MAXD   = BASE_TICKS << (NCODES - 1);
  localparam int CNT_W  = $clog2(MAXD + 1);

  logic             rst_n;
  logic             hold_req;
  logic             busy;
  logic [CNT_W-1:0] load_val;
  logic [CODE_W-1:0] code;

  assign hold_req = pri_rst | sec_rst;

  rsq_rst_sync u_sync (
    .clk   (clk),
    .por_n (por_n),
    .rst_n (rst_n)
  );

  rsq_cfg_reg #(
    .CODE_W       (CODE_W),
    .DEFAULT_CODE (DEFAULT_CODE)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .pri_rst  (pri_rst),
    .core_run (!rst_drv),
    .wr_en    (cfg_wr_en),
    .wr_code  (cfg_wr_code),
    .code     (code)
  );

  rsq_dur_decode #(
    .CODE_W     (CODE_W),
    .BASE_TICKS (BASE_TICKS),
    .CNT_W      (CNT_W)
  ) u_dec (
    .code  (code),
    .ticks (load_val)
  );

  rsq_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .tick     (tick),
    .load_val (load_val),
    .busy     (busy)
  );

  assign rst_drv     = hold_req | busy;
  assign clk_gate_en = ~rst_drv;
  assign cfg_rd_code = code;

  AST_RST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |-> rst_drv); // R1
  AST_GATE_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_en != rst_drv); // R3
  AST_SEC_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rst && !pri_rst) |=> $stable(code)); // R5
endmodule

// File: tb/sim_rst_seq_top.sv
module sim_rst_seq_top;
  localparam int CW   = 2;
  localparam int BASE = 2;
  localparam int DEF  = 1;

  logic          clk;
  logic          por_n;
  logic          pri_rst;
  logic          sec_rst;
  logic          tick;
  logic          cfg_wr_en;
  logic [CW-1:0] cfg_wr_code;
  logic [CW-1:0] cfg_rd_code;
  logic          rst_drv;
  logic          clk_gate_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rst_seq_top #(.CODE_W(CW), .BASE_TICKS(BASE), .DEFAULT_CODE(DEF)) u0 (
    .clk         (clk),
    .por_n       (por_n),
    .pri_rst     (pri_rst),
    .sec_rst     (sec_rst),
    .tick        (tick),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_code (cfg_wr_code),
    .cfg_rd_code (cfg_rd_code),
    .rst_drv     (rst_drv),
    .clk_gate_en (clk_gate_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input int exp_rst, input string req);
    chk(rst_drv == exp_rst[0], req, int'(rst_drv), exp_rst);
    chk(clk_gate_en == !exp_rst[0], "R3", int'(clk_gate_en), int'(!exp_rst[0]));
  endtask

  // Called at a negedge with both resets just released.
  task automatic run_count(input int d, input string req);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < d; i++) begin
      chk_out(1, req);
      @(posedge clk);
      @(negedge clk);
      chk_out(1, "R8");
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
    end
    chk_out(0, req);
  endtask

  task automatic write_code(input int c);
    cfg_wr_en   = 1'b1;
    cfg_wr_code = CW'(c);
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    por_n = 1'b0; pri_rst = 1'b1; sec_rst = 1'b1; tick = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_code = '0;
    repeat (3) @(negedge clk);
    chk_out(1, "R9");
    chk(cfg_rd_code == CW'(DEF), "R9", int'(cfg_rd_code), DEF);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_out(1, "R1");
    // ticks while asserted are ignored
    tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
    pri_rst = 1'b0; sec_rst = 1'b0;
    run_count(BASE << DEF, "R9");

    // sweep every code through a secondary reset cycle
    for (int c = 0; c < (1 << CW); c++) begin
      write_code(c);
      chk(cfg_rd_code == CW'(c), "R7", int'(cfg_rd_code), c);
      sec_rst = 1'b1;
      #0.1;
      chk_out(1, "R1");
      repeat (c + 1) @(negedge clk);
      chk(cfg_rd_code == CW'(c), "R5", int'(cfg_rd_code), c);
      sec_rst = 1'b0;
      run_count(BASE << c, "R2");
      chk(cfg_rd_code == CW'(c), "R5", int'(cfg_rd_code), c);
    end

    // primary reset restores default, write during reset ignored
    write_code(3);
    pri_rst = 1'b1;
    #0.1;
    chk_out(1, "R1");
    @(negedge clk);
    chk(cfg_rd_code == CW'(DEF), "R4", int'(cfg_rd_code), DEF);
    write_code(0);
    chk(cfg_rd_code == CW'(DEF), "R4", int'(cfg_rd_code), DEF);
    pri_rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    write_code(2);
    chk(cfg_rd_code == CW'(DEF), "R7", int'(cfg_rd_code), DEF);
    // finish the started count: load already done, one tick-free edge consumed
    for (int i = 0; i < (BASE << DEF); i++) begin
      chk_out(1, "R2");
      tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
    end
    chk_out(0, "R4");

    // cancellation in the middle of a count, both inputs
    for (int w = 0; w < 2; w++) begin
      write_code(2);
      sec_rst = 1'b1; @(negedge clk); sec_rst = 1'b0;
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < 5; i++) begin
        tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
      end
      chk_out(1, "R6");
      if (w == 0) sec_rst = 1'b1; else pri_rst = 1'b1;
      #0.1;
      chk_out(1, "R6");
      @(negedge clk);
      sec_rst = 1'b0; pri_rst = 1'b0;
      run_count(BASE << ((w == 0) ? 2 : DEF), "R6");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule